// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a single-clock core and an external asynchronous static RAM with a 17-bit address, an 8-bit data bus, a chip select pair made of one low-true and one high-true enable, a low-true write strobe and a low-true output enable. The core hands over one access at a time through a request/ready handshake. It supplies an address, write data and a write flag. A read returns its data on `rsp_rdata` together with a one-cycle `rsp_valid` pulse.

Every nanosecond minimum of the memory is expressed as a parameter. Each minimum is turned into a whole number of clock cycles by rounding up, and no wait state is shorter than one cycle. The sequence runs in a state machine with eight states:

- `ST_IDLE`
- `ST_READ_SETUP`
- `ST_READ_WAIT`
- `ST_READ_CAPTURE`
- `ST_TURNAROUND`
- `ST_WRITE_SETUP`
- `ST_WRITE_PULSE`
- `ST_WRITE_END`

The transitions are:

- `ST_IDLE` goes to `ST_WRITE_SETUP` or `ST_READ_SETUP` when a request is accepted.
- The read path runs setup → wait → capture → turnaround → idle.
- The write path runs setup → pulse → end → idle.
- Every non-idle state is left once its cycle count has elapsed.

All memory strobes and the data-bus drive enable are flip-flop outputs, decoded from the next state. The tri-state buffer itself stays outside the block: `mem_dq_out` and `mem_dq_oe` feed it, and `mem_dq_in` returns the pad value.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `req_ready` is high only in `ST_IDLE`. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the following cycle.
- R3: A write runs through three phases:
  - setup, lasting max(1, ceil(T_AW/P) max ceil(T_DW/P) − ceil(T_WP/P)) cycles;
  - `mem_we_n` low for ceil(T_WP/P) cycles;
  - a hold phase lasting max(1, ceil(T_CYC/P) − setup − pulse) cycles.

  `mem_dq_oe` is high and address and data are stable from setup until the cycle after `mem_we_n` rises. With the defaults (P=8 ns) `req_ready` is low for 3 cycles.
- R4: On every rising edge of `mem_we_n`, the following hold:
  - the low pulse has lasted at least T_WP (8 ns);
  - write data has been stable at least T_DW (7 ns);
  - the address has been stable at least T_AW (10 ns).
- R5: A read holds both enables active with `mem_we_n` high, spending one setup cycle and then a wait with `mem_oe_n` low. `rsp_rdata` is registered on the edge that ends the wait, and `rsp_valid` is high for exactly one cycle after that edge. With the defaults, this is the third cycle after the accepting edge.
- R6: Read data is sampled no earlier than T_AA (12 ns) after the address was set and no earlier than T_OE (6 ns) after `mem_oe_n` fell.
- R7: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: After `mem_oe_n` rises, `mem_dq_oe` stays low for at least T_OHZ (5 ns), provided by one capture cycle plus ceil(T_OHZ/P) turnaround cycles. With the defaults, a read keeps `req_ready` low for 4 cycles.
- R9: `mem_we_n` is low only while both enables are active and `mem_dq_oe` is high.
- R10: A read returns the byte most recently written to the same 17-bit address.
- R11: `rsp_valid` never pulses for a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous reset, low-true |
| req_valid | input | 1 | Core requests an access |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Registered read data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | Low-true chip enable |
| mem_ce | output | 1 | High-true chip enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dq_out | output | 8 | Data toward the pad buffer |
| mem_dq_oe | output | 1 | Pad buffer drive enable |
| mem_dq_in | input | 8 | Data from the pad |

## Verification
The sweeps use four groups of addresses:

- all-zero, all-one and a walking one across all 17 address bits, each carrying data computed from the address; this separates stuck or swapped address lines;
- an immediate read-back after each write over a block of spaced addresses, which exercises the write-to-read and read-to-write turnaround paths;
- reads in reverse order, which exposes any stale capture register;
- repeated reads of one address, which separates an address-timed capture from an enable-timed one.

The memory model in the bench hands out inverted data until both access times have elapsed, so an early capture shows up as wrong data. The model also flags short write pulses, short setups, bus contention and a short gap after the output enable rises.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_SETUP,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_TURNAROUND,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_END
    } ctrl_state_t;

    // ns minimum to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, floored at one cycle
    function automatic int unsigned sub_min1(input int unsigned a, input int unsigned b);
        return (a > b + 1) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
module asram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // load with N gives N cycles in the new state, done in the last one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_req_latch.sv
`timescale 1ns/1ps
module asram_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                rdata <= din;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WP_NS       = 8,
    parameter int T_DW_NS       = 7,
    parameter int T_AW_NS       = 10,
    parameter int T_AA_NS       = 12,
    parameter int T_OE_NS       = 6,
    parameter int T_OHZ_NS      = 5,
    parameter int T_CYC_NS      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // cycle counts derived from the ns minimums
    localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS,  CLK_PERIOD_NS);
    localparam int unsigned AW_CYC   = ns_to_cyc(T_AW_NS,  CLK_PERIOD_NS);
    localparam int unsigned DW_CYC   = ns_to_cyc(T_DW_NS,  CLK_PERIOD_NS);
    localparam int unsigned AA_CYC   = ns_to_cyc(T_AA_NS,  CLK_PERIOD_NS);
    localparam int unsigned OE_CYC   = ns_to_cyc(T_OE_NS,  CLK_PERIOD_NS);
    localparam int unsigned OHZ_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_CYC  = ns_to_cyc(T_CYC_NS, CLK_PERIOD_NS);

    localparam int unsigned WSU_CYC  = sub_min1(max_u(AW_CYC, DW_CYC), WP_CYC);
    localparam int unsigned WEND_CYC = sub_min1(CYC_CYC, WSU_CYC + WP_CYC);
    localparam int unsigned RSU_CYC  = 1;
    localparam int unsigned RW_CYC   = max_u(OE_CYC, max_u(sub_min1(AA_CYC, RSU_CYC),
                                                           sub_min1(CYC_CYC, RSU_CYC)));
    localparam int unsigned RC_CYC   = 1;
    localparam int unsigned TA_CYC   = OHZ_CYC;

    localparam int unsigned MAX_CYC  = max_u(max_u(max_u(WSU_CYC, WEND_CYC), max_u(WP_CYC, RW_CYC)),
                                             max_u(TA_CYC, 2));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    ctrl_state_t      state_q, state_d;
    logic             timer_load, timer_done;
    logic [CNT_W-1:0] timer_val;
    logic             accept, capture;
    logic             sel_d, drive_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_READ_WAIT) && timer_done;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (req_valid) state_d = req_write ? ST_WRITE_SETUP : ST_READ_SETUP;
            ST_READ_SETUP:   if (timer_done) state_d = ST_READ_WAIT;
            ST_READ_WAIT:    if (timer_done) state_d = ST_READ_CAPTURE;
            ST_READ_CAPTURE: if (timer_done) state_d = ST_TURNAROUND;
            ST_TURNAROUND:   if (timer_done) state_d = ST_IDLE;
            ST_WRITE_SETUP:  if (timer_done) state_d = ST_WRITE_PULSE;
            ST_WRITE_PULSE:  if (timer_done) state_d = ST_WRITE_END;
            ST_WRITE_END:    if (timer_done) state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // dwell length of the state being entered
    assign timer_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_READ_SETUP:   timer_val = CNT_W'(RSU_CYC);
            ST_READ_WAIT:    timer_val = CNT_W'(RW_CYC);
            ST_READ_CAPTURE: timer_val = CNT_W'(RC_CYC);
            ST_TURNAROUND:   timer_val = CNT_W'(TA_CYC);
            ST_WRITE_SETUP:  timer_val = CNT_W'(WSU_CYC);
            ST_WRITE_PULSE:  timer_val = CNT_W'(WP_CYC);
            ST_WRITE_END:    timer_val = CNT_W'(WEND_CYC);
            default:         timer_val = CNT_W'(1);
        endcase
    end

    // strobe decode from the next state, registered below
    always_comb begin
        unique case (state_d)
            ST_READ_SETUP, ST_READ_WAIT: begin
                sel_d   = 1'b1;
                drive_d = 1'b0;
            end
            ST_WRITE_SETUP, ST_WRITE_PULSE, ST_WRITE_END: begin
                sel_d   = 1'b1;
                drive_d = 1'b1;
            end
            default: begin
                sel_d   = 1'b0;
                drive_d = 1'b0;
            end
        endcase
    end

    // output register: every strobe leaves a flip-flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !sel_d;
            mem_ce    <= sel_d;
            mem_we_n  <= (state_d != ST_WRITE_PULSE);
            mem_oe_n  <= (state_d != ST_READ_WAIT);
            mem_dq_oe <= drive_d;
        end
    end

    asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    asram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_dq_in),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_write_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_valid_after_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(mem_oe_n));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_no_drive_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    p_write_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe));

    p_no_valid_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_dq_oe);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int PER = 8;

    // expected dwell counts, from the requirement formulas
    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int fl1(input int v);
        return (v < 1) ? 1 : v;
    endfunction
    localparam int EXP_WSU  = fl1(((cdiv(10) > cdiv(7)) ? cdiv(10) : cdiv(7)) - cdiv(8));
    localparam int EXP_WR_BUSY = EXP_WSU + cdiv(8) + fl1(cdiv(12) - EXP_WSU - cdiv(8));
    localparam int EXP_RD_BUSY = 1 + 1 + 1 + cdiv(5);
    localparam int EXP_RD_LAT  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] arr    [logic [AW-1:0]];
    logic [DW-1:0] refmem [logic [AW-1:0]];
    realtime t_addr = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0, t_data = 0;
    logic          mdrv = 1'b0;
    logic [DW-1:0] mdat = '0;
    wire           msel = !mem_ce_n && mem_ce;

    always @(mem_addr)                 t_addr    = $realtime;
    always @(negedge mem_oe_n)         t_oe_fall = $realtime;
    always @(posedge mem_oe_n)         t_oe_rise = $realtime;
    always @(negedge mem_we_n)         t_we_fall = $realtime;
    always @(mem_dq_out or mem_dq_oe)  t_data    = $realtime;

    always @(posedge mem_we_n) begin
        if (rst_n) begin
            // R9: write edge only while selected and driven
            if (!(msel && mem_dq_oe)) chk(1'b0, "R9 write while deselected", 0, 1);
            // R4: pulse width, data setup, address setup
            chk($realtime - t_we_fall >= 8.0, "R4 we pulse",    int'($realtime - t_we_fall), 8);
            chk($realtime - t_data    >= 7.0, "R4 data setup",  int'($realtime - t_data),    7);
            chk($realtime - t_addr    >= 10.0, "R4 addr setup", int'($realtime - t_addr),    10);
            if (msel) arr[mem_addr] = mem_dq_out;
        end
    end

    always @(posedge mem_dq_oe) begin
        if (rst_n && ($realtime - t_oe_rise < 5.0))
            chk(1'b0, "R8 turnaround gap", int'($realtime - t_oe_rise), 5);
    end

    initial begin
        #0.5;
        forever begin
            if (msel && mem_we_n && !mem_oe_n) begin
                mdrv = 1'b1;
                if (($realtime - t_addr >= 12.0) && ($realtime - t_oe_fall >= 6.0))
                    mdat = arr.exists(mem_addr) ? arr[mem_addr] : '0;
                else
                    mdat = ~(arr.exists(mem_addr) ? arr[mem_addr] : '0);
            end else if (mdrv && ($realtime - t_oe_rise >= 4.0)) begin
                mdrv = 1'b0;
            end
            if (mdrv && mem_dq_oe) chk(1'b0, "R7 bus contention", 1, 0);
            #1;
        end
    end

    assign mem_dq_in = mdrv ? mdat : (mem_dq_oe ? mem_dq_out : 8'hEE);

    // ---------------- stimulus ----------------
    task automatic idle_check(input string tag);
        chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, tag,
            {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 6'b101101);
    endtask

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int busy, output int lat, output int nval);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; lat = 0; nval = 0; rd = '0;
        while (!req_ready) begin
            busy++;
            if (rsp_valid) begin
                nval++;
                lat = busy;
                rd  = rsp_rdata;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int pass);
        return DW'(int'(a) * 29 + (int'(a) >> 9) + pass * 83 + 7);
    endfunction

    task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd;
        int busy, lat, nval;
        do_op(1'b1, a, d, rd, busy, lat, nval);
        refmem[a] = d;
        chk(busy == EXP_WR_BUSY, "R3 write busy cycles", busy, EXP_WR_BUSY);
        chk(nval == 0, "R11 no valid on write", nval, 0);
        idle_check("R1 idle after write");
    endtask

    task automatic rd_op(input logic [AW-1:0] a);
        logic [DW-1:0] rd;
        int busy, lat, nval;
        do_op(1'b0, a, '0, rd, busy, lat, nval);
        // R6 early sampling would return inverted data from the model
        chk(rd == refmem[a], "R10 R6 read data", int'(rd), int'(refmem[a]));
        chk(nval == 1, "R5 single valid pulse", nval, 1);
        chk(lat == EXP_RD_LAT, "R5 read latency", lat, EXP_RD_LAT);
        chk(busy == EXP_RD_BUSY, "R8 read busy cycles", busy, EXP_RD_BUSY);
        idle_check("R1 idle after read");
    endtask

    function automatic logic [AW-1:0] sweep_addr(input int i);
        if (i == 0)  return '0;
        if (i == AW + 1) return '1;
        return AW'(1) << (i - 1);
    endfunction

    initial begin : main
        repeat (4) @(negedge clk);
        idle_check("R1 reset state");
        chk(!rsp_valid, "R1 no valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 idle after reset");

        // walking-one address sweep: write all, then read all
        for (int i = 0; i <= AW + 1; i++) wr_op(sweep_addr(i), pat(sweep_addr(i), 0));
        for (int i = 0; i <= AW + 1; i++) rd_op(sweep_addr(i));

        // write then immediate read-back, spaced block
        for (int i = 0; i < 32; i++) begin
            logic [AW-1:0] a;
            a = AW'(17'h1_0000 + i * 3);
            wr_op(a, pat(a, 1));
            rd_op(a);
        end

        // reverse-order reads, then repeated reads of one address
        for (int i = AW + 1; i >= 0; i--) rd_op(sweep_addr(i));
        for (int i = 0; i < 4; i++) rd_op(AW'(17'h0_0100));

        // overwrite keeps only the newest byte
        wr_op(AW'(17'h0_0100), 8'h3C);
        wr_op(AW'(17'h0_0100), 8'hC3);
        rd_op(AW'(17'h0_0100));

        repeat (4) @(negedge clk);
        idle_check("R2 ready holds in idle");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule